// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a read-only line cache. Its main store is a direct-mapped tag/data array indexed by the low bits of the line address. Next to it sits a small fully associative side buffer that catches every valid line pushed out of the main array, so that two lines which keep colliding on one index no longer have to go back to the next level each time.

A requester presents a line address with a valid/ready handshake and gets back a one-cycle response pulse carrying the line and a hit flag. The main array is looked up in the acceptance cycle. If it misses, the side buffer is searched in the following cycle. A buffer hit swaps the two lines in one edge. A miss in both issues a request to the next level, waits for its response, installs the line in the main array and pushes the displaced line into the buffer. The buffer has four slots by default and a write pointer that goes round them, so it overwrites the slot filled longest ago.

The controller has four states. `ST_IDLE` accepts requests. A main hit returns to `ST_IDLE`, and a main miss moves to `ST_PROBE`. From `ST_PROBE` a buffer hit performs the swap and returns to `ST_IDLE`, while a buffer miss moves to `ST_FETCH`. `ST_FETCH` drives the next-level request and moves to `ST_WAIT` when that request is accepted. `ST_WAIT` returns to `ST_IDLE` in the cycle the next-level response arrives, and it fills the main array in that cycle.

Top module: `victim_backed_cache`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. All lines are invalid, so the first access to any address is a full miss.
- R2: A request that hits in the main array gives `rsp_valid`=1 with `rsp_hit`=1 and the stored line in the cycle after acceptance. It issues no next-level request.
- R3: A request that misses the main array but hits the side buffer gives `rsp_valid`=1 with `rsp_hit`=1 two cycles after acceptance. It issues no next-level request.
- R4: A request that misses both stores issues exactly one next-level request carrying the requested line address. It then responds with `rsp_hit`=0 and the returned line, one cycle after `mem_rsp_valid`.
- R5: After a fill, the next access to the same address is a main hit.
- R6: A valid line displaced from the main array by a fill is kept in the side buffer, and a later access to it is a buffer hit.
- R7: A buffer hit swaps the two lines. The requested line then hits in the main array, and the line it displaced becomes a buffer hit.
- R8: Two addresses with the same index (address bits [2:0] by default) accessed alternately both miss once. After that every access to either of them is a hit.
- R9: The side buffer holds four lines. A push into a full buffer overwrites the line pushed earliest, and that line then misses fully.
- R10: `req_ready` is 0 from the cycle after a main-miss acceptance until the cycle its response is presented. It is 1 again in that response cycle.
- R11: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready` is seen, and exactly one request is issued per full miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Line address of the request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | 1 if served from main array or side buffer |
| rsp_data | output | LINE_W | Returned line |
| mem_req_valid | output | 1 | Next-level fetch request |
| mem_req_ready | input | 1 | Next level accepts the fetch |
| mem_req_addr | output | ADDR_W | Line address to fetch |
| mem_rsp_valid | input | 1 | Next-level line returned |
| mem_rsp_data | input | LINE_W | Line returned by the next level |

## Verification
The bench alternates two lines that share one index and expects two-cycle hits on every round after the first. A design that drops the displaced line, or that swaps without writing back the resident line, would show repeated next-level requests here. It fills one index enough times to wrap the side buffer and then checks that only the earliest-pushed line was lost. A wrong pointer would either lose a younger line or keep the stale one. It stalls the next-level handshake to catch a request that is dropped or reissued. On every access it measures latency and the state of `req_ready`, so a design that overlaps a fill with a new acceptance, or adds a cycle to a hit, is reported.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FETCH = 2'd2,
        ST_WAIT  = 2'd3
    } vbc_state_e;
endpackage

// File: rtl/vbc_main_array.sv
module vbc_main_array #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int LINE_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic                    rd_valid,
    output logic [ADDR_W-IDX_W-1:0] rd_tag,
    output logic [LINE_W-1:0]       rd_data,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [ADDR_W-IDX_W-1:0] wr_tag,
    input  logic [LINE_W-1:0]       wr_data
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/vbc_side_buffer.sv
module vbc_side_buffer #(
    parameter int ADDR_W = 16,
    parameter int LINE_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        probe_addr,
    output logic                     probe_hit,
    output logic [$clog2(DEPTH)-1:0] probe_slot,
    output logic [LINE_W-1:0]        probe_data,
    input  logic                     swap_en,
    input  logic [$clog2(DEPTH)-1:0] swap_slot,
    input  logic                     swap_keep,
    input  logic [ADDR_W-1:0]        swap_addr,
    input  logic [LINE_W-1:0]        swap_data,
    input  logic                     push_en,
    input  logic [ADDR_W-1:0]        push_addr,
    input  logic [LINE_W-1:0]        push_data
);
    localparam int SLOT_W = $clog2(DEPTH);

    logic [DEPTH-1:0]  valid_q;
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LINE_W-1:0] data_q [DEPTH];
    logic [SLOT_W-1:0] ptr_q;
    logic [DEPTH-1:0]  match;

    // one comparator per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (addr_q[g] == probe_addr);
    end

    always_comb begin
        probe_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) probe_slot = SLOT_W'(i);
        end
    end

    assign probe_hit  = |match;
    assign probe_data = data_q[probe_slot];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (swap_en) begin
            valid_q[swap_slot] <= swap_keep;
        end else if (push_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == SLOT_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (swap_en) begin
            addr_q[swap_slot] <= swap_addr;
            data_q[swap_slot] <= swap_data;
        end else if (push_en) begin
            addr_q[ptr_q] <= push_addr;
            data_q[ptr_q] <= push_data;
        end
    end
endmodule

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
    import vbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int LINE_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     rsp_valid,
    output logic                     rsp_hit,
    output logic [LINE_W-1:0]        rsp_data,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [ADDR_W-1:0]        mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [LINE_W-1:0]        mem_rsp_data,
    output logic [ADDR_W-1:0]        lookup_addr,
    output logic                     main_hit,
    input  logic                     main_valid,
    input  logic [ADDR_W-IDX_W-1:0]  main_tag,
    input  logic [LINE_W-1:0]        main_data,
    output logic                     main_wr_en,
    output logic [LINE_W-1:0]        main_wr_data,
    input  logic                     vb_hit,
    input  logic [LINE_W-1:0]        vb_data,
    output logic                     vb_swap_en,
    output logic                     vb_push_en,
    output logic [ADDR_W-1:0]        evict_addr
);
    vbc_state_e        st_q, st_d;
    logic [ADDR_W-1:0] cur_q;
    logic              rsp_load, rsp_hit_d;
    logic [LINE_W-1:0] rsp_data_d;
    logic              rsp_valid_q, rsp_hit_q;
    logic [LINE_W-1:0] rsp_data_q;

    assign lookup_addr  = (st_q == ST_IDLE) ? req_addr : cur_q;
    assign main_hit     = main_valid && (main_tag == lookup_addr[ADDR_W-1:IDX_W]);
    assign evict_addr   = {main_tag, cur_q[IDX_W-1:0]};
    assign mem_req_addr = cur_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d          = st_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        main_wr_en    = 1'b0;
        main_wr_data  = vb_data;
        vb_swap_en    = 1'b0;
        vb_push_en    = 1'b0;
        rsp_load      = 1'b0;
        rsp_hit_d     = 1'b0;
        rsp_data_d    = main_data;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (main_hit) begin
                        rsp_load  = 1'b1;
                        rsp_hit_d = 1'b1;
                    end else begin
                        st_d = ST_PROBE;
                    end
                end
            end
            ST_PROBE: begin
                if (vb_hit) begin
                    main_wr_en   = 1'b1;
                    main_wr_data = vb_data;
                    vb_swap_en   = 1'b1;
                    rsp_load     = 1'b1;
                    rsp_hit_d    = 1'b1;
                    rsp_data_d   = vb_data;
                    st_d         = ST_IDLE;
                end else begin
                    st_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) st_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    main_wr_en   = 1'b1;
                    main_wr_data = mem_rsp_data;
                    vb_push_en   = main_valid;
                    rsp_load     = 1'b1;
                    rsp_data_d   = mem_rsp_data;
                    st_d         = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            if (st_q == ST_IDLE && req_valid) cur_q <= req_addr;
            rsp_valid_q <= rsp_load;
            if (rsp_load) begin
                rsp_hit_q  <= rsp_hit_d;
                rsp_data_q <= rsp_data_d;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_hit   = rsp_hit_q;
    assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/victim_backed_cache.sv
module victim_backed_cache #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 3,
    parameter int LINE_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [LINE_W-1:0] rsp_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [LINE_W-1:0] mem_rsp_data
);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SLOT_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] lookup_addr;
    logic              main_hit, main_valid, main_wr_en;
    logic [TAG_W-1:0]  main_tag;
    logic [LINE_W-1:0] main_data, main_wr_data;
    logic              vb_hit, vb_swap_en, vb_push_en;
    logic [SLOT_W-1:0] vb_slot;
    logic [LINE_W-1:0] vb_data;
    logic [ADDR_W-1:0] evict_addr;

    vbc_main_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_main (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lookup_addr[IDX_W-1:0]),
        .rd_valid (main_valid),
        .rd_tag   (main_tag),
        .rd_data  (main_data),
        .wr_en    (main_wr_en),
        .wr_idx   (mem_req_addr[IDX_W-1:0]),
        .wr_tag   (mem_req_addr[ADDR_W-1:IDX_W]),
        .wr_data  (main_wr_data)
    );

    vbc_side_buffer #(.ADDR_W(ADDR_W), .LINE_W(LINE_W), .DEPTH(DEPTH)) u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_addr (lookup_addr),
        .probe_hit  (vb_hit),
        .probe_slot (vb_slot),
        .probe_data (vb_data),
        .swap_en    (vb_swap_en),
        .swap_slot  (vb_slot),
        .swap_keep  (main_valid),
        .swap_addr  (evict_addr),
        .swap_data  (main_data),
        .push_en    (vb_push_en),
        .push_addr  (evict_addr),
        .push_data  (main_data)
    );

    vbc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .DEPTH(DEPTH)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_data      (rsp_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .lookup_addr   (lookup_addr),
        .main_hit      (main_hit),
        .main_valid    (main_valid),
        .main_tag      (main_tag),
        .main_data     (main_data),
        .main_wr_en    (main_wr_en),
        .main_wr_data  (main_wr_data),
        .vb_hit        (vb_hit),
        .vb_data       (vb_data),
        .vb_swap_en    (vb_swap_en),
        .vb_push_en    (vb_push_en),
        .evict_addr    (evict_addr)
    );
endmodule

// File: rtl/vbc_checker.sv
module vbc_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              main_hit
);
    p_main_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && main_hit |=> rsp_valid && rsp_hit);

    p_hit_no_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_hit |-> !$past(mem_req_valid));

    p_miss_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_hit |-> $past(mem_rsp_valid));

    p_miss_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !main_hit |=> !req_ready);

    p_fetch_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

bind victim_backed_cache vbc_checker #(.ADDR_W(ADDR_W)) u_vbc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .main_hit      (main_hit)
);

// File: tb/test_victim_backed_cache.sv
`timescale 1ns/1ps
module test_victim_backed_cache;
    localparam int AW = 16;
    localparam int LW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_hit;
    logic [LW-1:0] rsp_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [LW-1:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    int mem_reqs = 0;
    int drop_err = 0;
    int stall_cycles = 0;
    int mem_lat = 3;
    logic [AW-1:0] last_mem_addr = '0;

    always #10 clk = ~clk;

    victim_backed_cache i_victim_backed_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    function automatic logic [LW-1:0] line_of(input logic [AW-1:0] a);
        return {a, a ^ 16'hA5C3};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // next-level model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                for (int s = 0; s < stall_cycles; s++) begin
                    @(negedge clk);
                    if (!mem_req_valid) drop_err++;
                end
                mem_req_ready = 1'b1;
                last_mem_addr = mem_req_addr;
                mem_reqs++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int s = 1; s < mem_lat; s++) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = line_of(last_mem_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // exp_lat 0 means full miss, latency not fixed
    task automatic access(input logic [AW-1:0] a, input bit exp_hit,
                          input int exp_lat, input string req);
        int m0 = mem_reqs;
        int lat = 1;
        int ready_bad = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) ready_bad++;
            @(negedge clk);
            lat++;
        end
        chk(rsp_valid == 1'b1, req, "response seen", 64'(rsp_valid), 64'd1);
        chk(rsp_hit == exp_hit, req, "hit flag", 64'(rsp_hit), 64'(exp_hit));
        chk(rsp_data == line_of(a), req, "line data", 64'(rsp_data), 64'(line_of(a)));
        if (exp_lat > 0)
            chk(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        chk(mem_reqs - m0 == (exp_hit ? 0 : 1), req, "next-level requests",
            64'(mem_reqs - m0), 64'(exp_hit ? 0 : 1));
        if (!exp_hit)
            chk(last_mem_addr == a, "R4", "fetch address", 64'(last_mem_addr), 64'(a));
        if (lat > 1) begin
            chk(ready_bad == 0, "R10", "ready while busy", 64'(ready_bad), 64'd0);
            chk(req_ready == 1'b1, "R10", "ready at response", 64'(req_ready), 64'd1);
        end
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_fill_then_hit();
        access(16'h0011, 1'b0, 0, "R1");   // cold miss
        access(16'h0011, 1'b1, 1, "R5");   // now a main hit
        access(16'h0011, 1'b1, 1, "R2");
    endtask

    task automatic t_evict_swap();
        access(16'h0019, 1'b0, 0, "R4");   // same index, displaces 0x0011
        access(16'h0011, 1'b1, 2, "R6");   // buffer hit
        access(16'h0011, 1'b1, 1, "R7");   // swapped into main
        access(16'h0019, 1'b1, 2, "R7");   // displaced line in buffer
        access(16'h0019, 1'b1, 1, "R3");
    endtask

    task automatic t_pingpong();
        access(16'h0002, 1'b0, 0, "R8");
        access(16'h000A, 1'b0, 0, "R8");
        for (int k = 0; k < 4; k++) begin
            access(16'h0002, 1'b1, 2, "R8");
            access(16'h000A, 1'b1, 2, "R8");
        end
    endtask

    task automatic t_fifo();
        // index 5, six tags; the fifth push overwrites the first pushed (0x0005)
        for (int k = 0; k < 6; k++) access(16'(16'h0005 + 8 * k), 1'b0, 0, "R9");
        access(16'h000D, 1'b1, 2, "R9");   // second pushed survives
        access(16'h0015, 1'b1, 2, "R9");
        access(16'h0005, 1'b0, 0, "R9");   // earliest pushed was lost
    endtask

    task automatic t_stall();
        stall_cycles = 3;
        mem_lat = 5;
        drop_err = 0;
        access(16'h0007, 1'b0, 0, "R11");
        chk(drop_err == 0, "R11", "request dropped during stall", 64'(drop_err), 64'd0);
        access(16'h0007, 1'b1, 1, "R11");
        stall_cycles = 0;
        mem_lat = 3;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_then_hit();
        t_evict_swap();
        t_pingpong();
        t_fifo();
        t_stall();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule